// File: doc/BRIEF.md
# Channel Interrupt Aggregator

This block gathers the interrupt request lines of a four-channel bus switch into one shared interrupt output and a status view for the bus host. Each channel has an active-low request pin. The pins are brought into the clock domain through two-flop synchronizers. While any synchronized request is active, the block pulls the shared open-drain interrupt line low. A channel is watched whether or not it is currently routed.

A byte-wide control/status register sits on a simple strobe port. The low nibble is a channel-select field that the host writes and reads back. The high nibble is a snapshot of the pending requests. The snapshot is taken on each read strobe and holds its value until the next read. Nothing is latched: when a device drops its request, the status it reports and the shared output both follow the pin, and the host never has to clear anything.

Top module: `chan_irq_aggregator`

## Requirements
- R1: After a synchronous reset, the register reads 0x00 and the interrupt line is released (`irq_oe_o`=0, `irq_n_o`=1).
- R2: A request pin that goes low before clock edge k makes the output drive low (`irq_oe_o`=1, `irq_n_o`=0) after edge k+1, and not after edge k.
- R3: When every request pin is high again, the output is released with the same two-edge latency, and no register write is needed.
- R4: A read strobe at an edge loads each status bit from the synchronized pin state. Bit 4+i stands for channel i (bit 4 = channel 0 through bit 7 = channel 3), and 1 means pending (the pin is low).
- R5: Between read strobes the status nibble holds its value, even when the request pins change.
- R6: Any combination of channels may be pending at once and is reported bit-exact, for example a status nibble of 0110 for channels 1 and 2.
- R7: A request is detected and reported whatever value the select field holds.
- R8: A write strobe loads `wr_data_i[3:0]` into the select field, which is returned unchanged in `rd_data_o[3:0]`.
- R9: Write data in bits 7..4 has no effect on the register.
- R10: A request pin tied high reads as not pending and never drives the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n_i | input | 4 | Per-channel interrupt requests, active low, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; captures the status nibble |
| wr_data_i | input | 8 | Write data; only bits 3..0 are used |
| rd_data_o | output | 8 | Register contents: {status[3:0], select[3:0]} |
| irq_oe_o | output | 1 | Open-drain enable; 1 pulls the shared line low |
| irq_n_o | output | 1 | Modelled line level: 0 while driven, 1 when released |

## Verification
A synchronizer stage stuck or skipped shows up at the output one edge early or late, or never, within three cycles of a pin change. The bench checks both edges of that window. A status capture that is wrong in bit order, polarity, or timing shows up in the first read after the bad state, because each read returns the full nibble. A status register that updates without a read, or a select field that takes the upper write bits, changes `rd_data_o` between strobes. The bench samples the register in those intervals to catch it.

// File: rtl/irq_agg_pkg.sv
// Package: shared sizes for the channel interrupt aggregator.
// Assumes one request line per channel and a select field of equal width.
package irq_agg_pkg;
    parameter int unsigned NUM_CH   = 4;
    parameter int unsigned SEL_W    = 4;
    parameter int unsigned SYNC_LEN = 2;
    localparam int unsigned REG_W   = NUM_CH + SEL_W;

    typedef logic [NUM_CH-1:0] ch_vec_t;
    typedef logic [SEL_W-1:0]  sel_t;
endpackage

// File: rtl/chan_req_sync.sv
// Module: chan_req_sync
// Brings each active-low request pin into the clock domain through a
// SYNC_LEN-stage flop chain. It outputs an active-high pending vector.
// Assumes: the pins are asynchronous; reset loads the released level (1).
module chan_req_sync #(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_n_i,
    output logic [NUM_CH-1:0] pending_o
);
    localparam int unsigned LAST = SYNC_LEN - 1;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [SYNC_LEN-1:0] chain_q;

        // Shift the raw pin level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[SYNC_LEN-2:0], req_n_i[ch]};
            end
        end

        // Convert the settled active-low level to active-high pending.
        always_comb begin
            pending_o[ch] = ~chain_q[LAST];
        end
    end
endmodule

// File: rtl/irq_combiner.sv
// Module: irq_combiner
// ORs the pending vector into the shared open-drain interrupt. It drives
// an output enable and a modelled line level (low while driven).
// Assumes: the pending vector is already synchronous.
module irq_combiner #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pending_i,
    output logic              irq_oe_o,
    output logic              irq_n_o
);
    // Drive the shared line while any channel is pending.
    always_comb begin
        irq_oe_o = |pending_i;
        irq_n_o  = ~(|pending_i);
    end

    // R3
    // With no channel pending, the line must be released.
    release_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_i == '0) |-> (irq_oe_o == 1'b0 && irq_n_o == 1'b1));
endmodule

// File: rtl/ctrl_status_reg.sv
// Module: ctrl_status_reg
// Holds the control/status byte: {status, select}. The select field is
// written by the write strobe. The status field is loaded from the pending
// vector on the read strobe only.
// Assumes: strobes are single-cycle and synchronous to clk.
module ctrl_status_reg #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned SEL_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr_i,
    input  logic                    reg_rd_i,
    input  logic [NUM_CH+SEL_W-1:0] wr_data_i,
    input  logic [NUM_CH-1:0]       pending_i,
    output logic [NUM_CH+SEL_W-1:0] rd_data_o
);
    logic [SEL_W-1:0]  sel_q;
    logic [NUM_CH-1:0] stat_q;

    // Load the select field from the low write-data bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (reg_wr_i) begin
            sel_q <= wr_data_i[SEL_W-1:0];
        end
    end

    // Take a status snapshot of the pending vector on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (reg_rd_i) begin
            stat_q <= pending_i;
        end
    end

    // Present the register image: status above select.
    always_comb begin
        rd_data_o = {stat_q, sel_q};
    end

    // R1
    // The cycle after reset, both fields are cleared.
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (stat_q == '0 && sel_q == '0));

    // R4
    // A read loads the pending state seen at that edge.
    capture_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_i |=> (stat_q == $past(pending_i)));

    // R5
    // Without a read, the status snapshot does not move.
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd_i && !$past(!rst_n)) |=> $stable(stat_q));

    // R8
    // Without a write, the select field does not move.
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |=> $stable(sel_q));

    // R9
    // A write takes only the low data bits.
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i |=> (sel_q == $past(wr_data_i[SEL_W-1:0])));
endmodule

// File: rtl/chan_irq_aggregator.sv
// Module: chan_irq_aggregator (top)
// Synchronizes the per-channel request pins and drives the shared
// open-drain interrupt. It also exposes the control/status byte on a
// strobe port. Detection does not depend on the select field.
// Assumes: synchronous active-low reset; single-cycle register strobes.
module chan_irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       req_n_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [7:0]       wr_data_i,
    output logic [7:0]       rd_data_o,
    output logic             irq_oe_o,
    output logic             irq_n_o
);
    ch_vec_t pending;

    chan_req_sync #(
        .NUM_CH   (NUM_CH),
        .SYNC_LEN (SYNC_LEN)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n_i   (req_n_i),
        .pending_o (pending)
    );

    irq_combiner #(
        .NUM_CH (NUM_CH)
    ) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .irq_oe_o  (irq_oe_o),
        .irq_n_o   (irq_n_o)
    );

    ctrl_status_reg #(
        .NUM_CH (NUM_CH),
        .SEL_W  (SEL_W)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_i  (reg_wr_i),
        .reg_rd_i  (reg_rd_i),
        .wr_data_i (wr_data_i),
        .pending_i (pending),
        .rd_data_o (rd_data_o)
    );

    // R2
    // Two cycles of a held-low pin must reach the output.
    assert_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && ($past(req_n_i, 2) != 4'hF) && ($past(req_n_i) != 4'hF)
         && ($past(req_n_i, 2) == $past(req_n_i)))
        |-> irq_oe_o);
endmodule

// File: tb/chan_irq_aggregator_bench.sv
`timescale 1ns/1ps
module chan_irq_aggregator_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_n_i = 4'hF;
    logic       reg_wr_i = 1'b0;
    logic       reg_rd_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       irq_oe_o;
    logic       irq_n_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       chk_due = 1'b0;
    logic [3:0] sel_model = 4'h0;

    always #2.5 clk = ~clk;

    chan_irq_aggregator u_chan_irq_aggregator (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n_i   (req_n_i),
        .reg_wr_i  (reg_wr_i),
        .reg_rd_i  (reg_rd_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .irq_oe_o  (irq_oe_o),
        .irq_n_o   (irq_n_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Driver: issue a read and queue the expected register image.
    task automatic do_read(input string req);
        @(negedge clk);
        exp_q.push_back({~req_n_i, sel_model});
        tag_q.push_back(req);
        reg_rd_i = 1'b1;
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_data_i = d;
        reg_wr_i  = 1'b1;
        sel_model = d[3:0];
        @(negedge clk);
        reg_wr_i  = 1'b0;
    endtask

    task automatic set_req(input logic [3:0] v);
        @(negedge clk);
        req_n_i = v;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: a read seen at an edge is compared at the next falling edge.
    always @(posedge clk) chk_due <= reg_rd_i;
    always @(negedge clk) begin
        if (chk_due) begin
            if (exp_q.size() == 0) begin
                check("scoreboard-empty", 8'h00, 8'hFF);
            end else begin
                check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_data", rd_data_o, 8'h00);
        check("R1 irq_oe", {7'd0, irq_oe_o}, 8'h00);
        check("R1 irq_n", {7'd0, irq_n_o}, 8'h01);

        // R2 two-edge latency to assert
        @(negedge clk);
        req_n_i = 4'b1101;
        @(negedge clk);
        check("R2 not after first edge", {7'd0, irq_oe_o}, 8'h00);
        @(negedge clk);
        check("R2 driven after second edge", {7'd0, irq_oe_o}, 8'h01);
        check("R2 line low", {7'd0, irq_n_o}, 8'h00);
        do_read("R4 channel 1 to bit 5");

        // R3 release with the same latency, no write
        @(negedge clk);
        req_n_i = 4'hF;
        @(negedge clk);
        check("R3 still driven after first edge", {7'd0, irq_oe_o}, 8'h01);
        @(negedge clk);
        check("R3 released after second edge", {7'd0, irq_n_o}, 8'h01);
        do_read("R3 status cleared by pin");

        // R4/R6 single channels and combinations
        for (int i = 0; i < 4; i++) begin
            set_req(~(4'b0001 << i));
            do_read("R4 single channel mapping");
        end
        set_req(4'b1001);
        do_read("R6 channels 1 and 2 give 0110");
        set_req(4'b0000);
        do_read("R6 all channels pending");

        // R7 detection independent of select
        do_write(8'h01);
        set_req(4'b0111);
        check("R7 irq with other channel selected", {7'd0, irq_oe_o}, 8'h01);
        do_read("R7 channel 3 reported with select 1");

        // R9 upper write bits ignored; R8 select returned
        do_write(8'hF5);
        set_req(4'hF);
        do_read("R9 upper write bits ignored");
        do_write(8'h0A);
        do_read("R8 select readback");

        // R5 status holds between reads
        set_req(4'b1110);
        do_read("R5 baseline");
        snap = rd_data_o;
        set_req(4'b0001);
        check("R5 status held without read", rd_data_o, snap);
        set_req(4'hF);
        check("R5 status held after release", rd_data_o, snap);

        // R10 tied-high inputs
        check("R10 no drive with all high", {7'd0, irq_oe_o}, 8'h00);
        do_read("R10 all tied high read as idle");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) check("scoreboard-leftover", 8'(exp_q.size()), 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule